// File: doc/BRIEF.md
# Video Switch-Matrix Controller with Serial Write Port

This block holds the control state for a five-group analogue video switch matrix. The groups are: luma/chroma pair 0, pair 1 and pair 2, plus two colour-and-blanking sets. Its output is one enable bit per group. The analogue switches themselves sit outside the block and read these enables.

In serial mode the block is a receive-only two-wire (I2C) slave:

- A fast system clock samples the clock line and the data line.
- The block recognises its own write address and acknowledges it.
- Each complete data byte that follows is written straight into the enables.

In direct mode the three control pins stop acting as a bus. They are decoded without any clocking into a fixed set of eight switch patterns. Any transfer in progress is dropped when the block enters direct mode. The value last written over the bus is kept and shows again when the block returns to serial mode.

Top module: `vidsel_ctrl`

## Requirements
- R1: In serial mode the block acknowledges an address byte equal to binary 1101_10 followed by the inverse of `sel_pin` and then a 0 write bit. That is 0xDA when `sel_pin`=0 and 0xD8 when `sel_pin`=1. Bytes are received MSB first.
- R2: An address byte with the write bit set to 1, or with any other address, gets no acknowledge. Data bytes that follow it, up to the next START, change nothing.
- R3: After an accepted address byte and after every data byte that follows it, `sda_pull_n` goes low during the ninth clock pulse. It is released at the falling SCL edge that ends that pulse.
- R4: A data byte sets `sw_en` from its bits 4..0. Bit 0 is pair 0, bit 1 is pair 1, bit 2 is pair 2, bit 3 is set 1 and bit 4 is set 2, with 1 meaning on. Bits 7..5 have no effect.
- R5: Every further data byte after the address updates `sw_en` again. After a STOP, further bytes sent without a START are ignored.
- R6: A STOP that arrives in the middle of a byte leaves `sw_en` at the value of the last complete data byte.
- R7: After reset in serial mode, `sw_en` is all zero and `sda_pull_n` is 1.
- R8: With `direct_mode`=1, `sw_en` follows the code {`sel_pin`,`sda_pin`,`scl_pin`} with no clock delay:

  | Code | `sw_en` |
  |------|---------|
  | 000 | 00000 |
  | 001 | 00001 |
  | 010 | 00010 |
  | 011 | 00100 |
  | 100 | 01000 |
  | 101 | 10000 |
  | 110 | 01010 |
  | 111 | 10100 |

- R9: A START at any bit position resets reception, so the next eight bits are read as an address byte.
- R10: Raising `direct_mode` abandons any transfer and releases `sda_pull_n`. The serially written value is kept, shows again once `direct_mode` returns to 0, and no transfer resumes without a new START.
- R11: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. SDA changes while SCL is low are data, not bus conditions.
- R12: A pulse on `scl_pin` lasting one system clock is rejected by the line filter and does not count as a bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 20 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| direct_mode | input | 1 | 1 selects direct pin decode, 0 selects the serial bus |
| sel_pin | input | 1 | Address select in serial mode; code bit 2 in direct mode |
| scl_pin | input | 1 | Bus clock in serial mode; code bit 0 in direct mode |
| sda_pin | input | 1 | Bus data as seen on the wire; code bit 1 in direct mode |
| sda_pull_n | output | 1 | Open-drain data drive: 0 pulls SDA low |
| sw_en | output | 5 | Switch-group enables |

## Verification
The bench targets these corner cases:

- **STOP mid-byte.** A design that latched partial bytes would show a shifted pattern on `sw_en`.
- **Repeated START partway through a data byte.** A bit counter that is not cleared would misread the following address byte.
- **Read-direction address and the address of the other select setting.** A design that ignored the write bit or the inverted select bit would acknowledge them and take the data.
- **Leaving direct mode in the middle of a transfer.** Bytes sent afterwards without a START must be ignored; a design that did not abandon the transfer would latch them.
- **One-cycle glitch on SCL.** A missing filter would count it as an extra bit and misalign every later bit.

// File: rtl/vidsel_pkg.sv
package vidsel_pkg;

    localparam int NUM_GROUPS  = 5;
    localparam int BYTE_BITS   = 8;
    localparam int CNT_W       = $clog2(BYTE_BITS + 1);
    localparam int CODE_W      = 3;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_ADDR,
        RX_ADDR_ACK,
        RX_DATA,
        RX_DATA_ACK
    } rx_state_e;

    // Direct-mode code to group enables (bit0 pair0 .. bit4 set2)
    function automatic logic [NUM_GROUPS-1:0] direct_map(input logic [CODE_W-1:0] code);
        logic [NUM_GROUPS-1:0] m;
        unique case (code)
            3'd0:    m = 5'b00000;
            3'd1:    m = 5'b00001;
            3'd2:    m = 5'b00010;
            3'd3:    m = 5'b00100;
            3'd4:    m = 5'b01000;
            3'd5:    m = 5'b10000;
            3'd6:    m = 5'b01010;
            default: m = 5'b10100;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/vidsel_linefilt.sv
module vidsel_linefilt #(
    parameter int SYNC_STAGES = 2,
    parameter int VOTE_TAPS   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);

    localparam int HALF = VOTE_TAPS / 2;
    localparam int VW   = $clog2(VOTE_TAPS + 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [VOTE_TAPS-1:0]   win;
        logic                   clean;
    } filt_t;

    filt_t st_d, st_q;
    logic [VW-1:0] votes;

    always_comb begin
        st_d       = st_q;
        st_d.sync  = {st_q.sync[SYNC_STAGES-2:0], raw};
        st_d.win   = {st_q.win[VOTE_TAPS-2:0], st_q.sync[SYNC_STAGES-1]};
        votes      = '0;
        for (int i = 0; i < VOTE_TAPS; i++) begin
            votes = votes + VW'(st_q.win[i]);
        end
        st_d.clean = (votes > VW'(HALF));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sync: '1, win: '1, clean: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign clean = st_q.clean;

endmodule

// File: rtl/vidsel_i2c_rx.sv
module vidsel_i2c_rx
    import vidsel_pkg::*;
#(
    parameter logic [5:0] ADDR_HI = 6'b110110
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  halt,
    input  logic                  addr_lsb,
    input  logic                  scl,
    input  logic                  sda,
    output logic [NUM_GROUPS-1:0] sw_q,
    output logic                  drv_n
);

    typedef struct packed {
        rx_state_e              state;
        logic [CNT_W-1:0]       bits;
        logic [BYTE_BITS-1:0]   shreg;
        logic                   scl_p;
        logic                   sda_p;
        logic [NUM_GROUPS-1:0]  sw;
        logic                   drv_n;
    } rx_t;

    rx_t  r_d, r_q;
    logic scl_rise, scl_fall, cond_start, cond_stop, byte_done;
    logic [BYTE_BITS-1:0] own_addr;

    always_comb begin
        own_addr   = {ADDR_HI, addr_lsb, 1'b0};
        scl_rise   = scl & ~r_q.scl_p;
        scl_fall   = ~scl & r_q.scl_p;
        cond_start = r_q.scl_p & scl & r_q.sda_p & ~sda;
        cond_stop  = r_q.scl_p & scl & ~r_q.sda_p & sda;
        byte_done  = scl_fall && (r_q.bits == CNT_W'(BYTE_BITS));

        r_d       = r_q;
        r_d.scl_p = scl;
        r_d.sda_p = sda;

        if (halt) begin
            r_d.state = RX_IDLE;
            r_d.bits  = '0;
            r_d.drv_n = 1'b1;
        end else if (cond_start) begin
            r_d.state = RX_ADDR;
            r_d.bits  = '0;
            r_d.drv_n = 1'b1;
        end else if (cond_stop) begin
            r_d.state = RX_IDLE;
            r_d.bits  = '0;
            r_d.drv_n = 1'b1;
        end else begin
            unique case (r_q.state)
                RX_ADDR, RX_DATA: begin
                    if (scl_rise) begin
                        r_d.shreg = {r_q.shreg[BYTE_BITS-2:0], sda};
                        r_d.bits  = r_q.bits + 1'b1;
                    end
                    if (byte_done) begin
                        r_d.bits = '0;
                        if (r_q.state == RX_ADDR) begin
                            if (r_q.shreg == own_addr) begin
                                r_d.state = RX_ADDR_ACK;
                                r_d.drv_n = 1'b0;
                            end else begin
                                r_d.state = RX_IDLE;
                            end
                        end else begin
                            r_d.sw    = r_q.shreg[NUM_GROUPS-1:0];
                            r_d.state = RX_DATA_ACK;
                            r_d.drv_n = 1'b0;
                        end
                    end
                end
                RX_ADDR_ACK, RX_DATA_ACK: begin
                    if (scl_fall) begin
                        r_d.state = RX_DATA;
                        r_d.bits  = '0;
                        r_d.drv_n = 1'b1;
                    end
                end
                default: begin
                    r_d.bits = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: RX_IDLE, bits: '0, shreg: '0, scl_p: 1'b1,
                     sda_p: 1'b1, sw: '0, drv_n: 1'b1};
        end else begin
            r_q <= r_d;
        end
    end

    assign sw_q  = r_q.sw;
    assign drv_n = r_q.drv_n;

endmodule

// File: rtl/vidsel_direct_dec.sv
module vidsel_direct_dec
    import vidsel_pkg::*;
(
    input  logic                  code_hi,
    input  logic                  code_mid,
    input  logic                  code_lo,
    output logic [NUM_GROUPS-1:0] sw
);

    always_comb begin
        sw = direct_map({code_hi, code_mid, code_lo});
    end

endmodule

// File: rtl/vidsel_ctrl.sv
module vidsel_ctrl
    import vidsel_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter int         VOTE_TAPS   = 3,
    parameter logic [5:0] ADDR_HI     = 6'b110110
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  direct_mode,
    input  logic                  sel_pin,
    input  logic                  scl_pin,
    input  logic                  sda_pin,
    output logic                  sda_pull_n,
    output logic [NUM_GROUPS-1:0] sw_en
);

    localparam int NLINES = 2;

    logic [NLINES-1:0]     line_raw;
    logic [NLINES-1:0]     line_clean;
    logic [NUM_GROUPS-1:0] serial_sw;
    logic [NUM_GROUPS-1:0] direct_sw;

    assign line_raw = {sda_pin, scl_pin};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        vidsel_linefilt #(
            .SYNC_STAGES(SYNC_STAGES),
            .VOTE_TAPS  (VOTE_TAPS)
        ) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (line_raw[g]),
            .clean(line_clean[g])
        );
    end

    vidsel_i2c_rx #(
        .ADDR_HI(ADDR_HI)
    ) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .halt    (direct_mode),
        .addr_lsb(~sel_pin),
        .scl     (line_clean[0]),
        .sda     (line_clean[1]),
        .sw_q    (serial_sw),
        .drv_n   (sda_pull_n)
    );

    vidsel_direct_dec u_dec (
        .code_hi (sel_pin),
        .code_mid(sda_pin),
        .code_lo (scl_pin),
        .sw      (direct_sw)
    );

    always_comb begin
        sw_en = direct_mode ? direct_sw : serial_sw;
    end

endmodule

// File: rtl/vidsel_ctrl_chk.sv
module vidsel_ctrl_chk
    import vidsel_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  direct_mode,
    input logic                  sda_pull_n,
    input logic                  scl_clean,
    input logic [NUM_GROUPS-1:0] sw_en,
    input logic [NUM_GROUPS-1:0] serial_sw
);

    // R10
    direct_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (direct_mode && $past(direct_mode)) |-> sda_pull_n);

    // R10
    serial_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (direct_mode && $past(direct_mode)) |-> $stable(serial_sw));

    // R3
    latch_acks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(serial_sw) |-> !sda_pull_n);

    // R3
    ack_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull_n) |-> !scl_clean);

    // R8
    direct_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        direct_mode |-> ($countones(sw_en) <= 2));

endmodule

bind vidsel_ctrl vidsel_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .direct_mode(direct_mode),
    .sda_pull_n (sda_pull_n),
    .scl_clean  (line_clean[0]),
    .sw_en      (sw_en),
    .serial_sw  (serial_sw)
);

// File: tb/vidsel_ctrl_bench.sv
`timescale 1ns/1ps
module vidsel_ctrl_bench;

    localparam int H      = 40;
    localparam int SETTLE = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic direct_mode = 1'b0;
    logic sel_pin = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_bus;
    logic sda_pull_n;
    logic [4:0] sw_en;

    always #2 clk = ~clk;

    assign sda_bus = sda_m & sda_pull_n;

    vidsel_ctrl u_vidsel_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .direct_mode(direct_mode),
        .sel_pin    (sel_pin),
        .scl_pin    (scl_m),
        .sda_pin    (sda_bus),
        .sda_pull_n (sda_pull_n),
        .sw_en      (sw_en)
    );

    // reference model state
    int         n_cmp = 0;
    int         n_bad = 0;
    int         settle = SETTLE;
    bit         run_cmp = 0;
    string      cur_req = "R7";
    logic [4:0] exp_serial = '0;
    logic       exp_drv_n = 1'b1;
    int         mstate = 0; // 0 idle, 1 expecting address, 2 addressed
    logic [4:0] dtab [8] = '{5'h00, 5'h01, 5'h02, 5'h04, 5'h08, 5'h10, 5'h0A, 5'h14};

    function automatic logic [4:0] model_sw();
        if (direct_mode) return dtab[{sel_pin, sda_bus, scl_m}];
        return exp_serial;
    endfunction

    always @(negedge clk) begin
        if (run_cmp) begin
            if (settle > 0) settle--;
            else begin
                logic [4:0] e;
                e = model_sw();
                n_cmp++;
                if (sw_en !== e || sda_pull_n !== exp_drv_n) begin
                    n_bad++;
                    $display("FAIL %s: sw_en=%h pull_n=%b expected sw_en=%h pull_n=%b",
                             cur_req, sw_en, sda_pull_n, e, exp_drv_n);
                end
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(bit ok, string req, int act, int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; step(H/2);
        scl_m = 1'b1; step(H);
        sda_m = 1'b0; mstate = 1; exp_drv_n = 1'b1; settle = SETTLE; step(H);
        scl_m = 1'b0; step(H/2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; step(H/2);
        scl_m = 1'b1; step(H);
        sda_m = 1'b1; mstate = 0; settle = SETTLE; step(H);
    endtask

    task automatic scl_park_low();
        scl_m = 1'b0; step(H/2);
    endtask

    task automatic send_bit(logic b, bit glitch);
        sda_m = b;
        if (glitch) begin
            step(H/4); scl_m = 1'b1; step(1); scl_m = 1'b0; step(H/4 - 1);
        end else begin
            step(H/2);
        end
        scl_m = 1'b1; step(H);
        scl_m = 1'b0; step(H/2);
    endtask

    task automatic send_bits(logic [7:0] b, int n);
        for (int i = 7; i > 7 - n; i--) send_bit(b[i], 1'b0);
    endtask

    // full byte plus ninth pulse; model decides acknowledge and latch
    task automatic send_byte(logic [7:0] b, string req, bit glitch = 0);
        bit acked;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i];
            if (glitch && i == 4) begin
                step(H/4); scl_m = 1'b1; step(1); scl_m = 1'b0; step(H/4 - 1);
            end else begin
                step(H/2);
            end
            scl_m = 1'b1; step(H);
            scl_m = 1'b0;
            if (i == 0) begin
                acked = 0;
                if (mstate == 1) begin
                    acked = (b == {6'b110110, ~sel_pin, 1'b0});
                    mstate = acked ? 2 : 0;
                end else if (mstate == 2) begin
                    acked = 1;
                    exp_serial = b[4:0];
                end
                exp_drv_n = ~acked;
                settle = SETTLE;
                cur_req = req;
            end
            step(H/2);
        end
        sda_m = 1'b1; step(H/2);
        scl_m = 1'b1; step(H/2);
        check(sda_bus == ~acked, "R3", sda_bus, ~acked);
        step(H/2);
        scl_m = 1'b0; exp_drv_n = 1'b1; settle = SETTLE; step(H/2);
    endtask

    task automatic enter_direct(logic [2:0] code);
        direct_mode = 1'b1; mstate = 0; exp_drv_n = 1'b1;
        {sel_pin, sda_m, scl_m} = code;
        settle = SETTLE; step(SETTLE + 4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        step(10);
        rst_n = 1'b1;
        step(2);
        // R7 reset state
        check(sw_en == 5'h00, "R7", sw_en, 0);
        check(sda_pull_n == 1'b1, "R7", sda_pull_n, 1);
        run_cmp = 1; settle = 0;
        step(20);

        // R1 R4 R5: address, several data bytes, upper bits ignored
        cur_req = "R1";
        bus_start();
        send_byte(8'hDA, "R1");
        send_byte(8'h05, "R4");
        send_byte(8'hEA, "R4");
        send_byte(8'h13, "R5");
        bus_stop();
        step(H);
        check(sw_en == 5'h13, "R5", sw_en, 5'h13);

        // R5 bytes after STOP without START ignored
        scl_park_low();
        send_byte(8'h1F, "R5");
        send_byte(8'h00, "R5");
        check(sw_en == 5'h13, "R5", sw_en, 5'h13);
        bus_stop();

        // R6 STOP mid-byte
        bus_start();
        send_byte(8'hDA, "R6");
        send_byte(8'h09, "R6");
        send_bits(8'h16, 4);
        cur_req = "R6";
        bus_stop();
        step(H);
        check(sw_en == 5'h09, "R6", sw_en, 5'h09);

        // R2 read request rejected, data ignored
        bus_start();
        send_byte(8'hDB, "R2");
        send_byte(8'h1F, "R2");
        check(sw_en == 5'h09, "R2", sw_en, 5'h09);
        bus_stop();

        // R1 R2 select pin inverts address LSB
        sel_pin = 1'b1; step(4);
        bus_start();
        send_byte(8'hDA, "R2");
        send_byte(8'h1F, "R2");
        check(sw_en == 5'h09, "R2", sw_en, 5'h09);
        bus_stop();
        bus_start();
        send_byte(8'hD8, "R1");
        send_byte(8'h11, "R1");
        bus_stop();
        check(sw_en == 5'h11, "R1", sw_en, 5'h11);
        sel_pin = 1'b0; step(4);

        // R9 repeated START mid data byte; R11 data edges not conditions
        bus_start();
        send_byte(8'hDA, "R9");
        send_byte(8'h03, "R9");
        send_bits(8'hA5, 5);
        cur_req = "R9";
        bus_start();
        send_byte(8'hDA, "R9");
        send_byte(8'h0C, "R11");
        bus_stop();
        check(sw_en == 5'h0C, "R9", sw_en, 5'h0C);

        // R12 one-cycle SCL glitch inside a data byte
        bus_start();
        send_byte(8'hDA, "R12");
        send_byte(8'h15, "R12", 1);
        bus_stop();
        check(sw_en == 5'h15, "R12", sw_en, 5'h15);

        // R8 direct decode of all codes
        cur_req = "R8";
        enter_direct(3'b000);
        for (int c = 0; c < 8; c++) begin
            {sel_pin, sda_m, scl_m} = 3'(c);
            step(3);
            check(sw_en == dtab[c], "R8", sw_en, dtab[c]);
        end
        {sel_pin, sda_m, scl_m} = 3'b011; step(4);
        direct_mode = 1'b0; settle = SETTLE; cur_req = "R10"; step(H);
        check(sw_en == 5'h15, "R10", sw_en, 5'h15);

        // R10 mode change mid-transfer abandons it
        bus_start();
        send_byte(8'hDA, "R10");
        send_bits(8'h0E, 3);
        cur_req = "R10";
        enter_direct(3'b101);
        check(sw_en == 5'h10, "R8", sw_en, 5'h10);
        {sel_pin, sda_m, scl_m} = 3'b011; step(SETTLE);
        direct_mode = 1'b0; settle = SETTLE; step(H);
        check(sw_en == 5'h15, "R10", sw_en, 5'h15);
        scl_park_low();
        send_byte(8'h0E, "R10");
        check(sw_en == 5'h15, "R10", sw_en, 5'h15);
        bus_stop();
        step(H);

        run_cmp = 0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule